// File: doc/BRIEF.md
# Extended DMA Transfer Controller

This block runs the playback and record DMA transfers of an audio converter channel in its extended operating mode. A command decoder writes eight-bit values into a small set of indexed control registers. From those registers the block decides four things: when a transfer may run, in which direction it runs, which sample format it carries and how many transfers make up one block. While a transfer is running it raises a DMA request on either the byte-wide or the word-wide channel. Each acknowledged transfer advances a 16-bit up-counter. When the counter overflows, the block pulses an interrupt.

The block length is programmed as a two's-complement start value. The counter begins at that value and counts up, so the number of transfers in a block is 0x10000 minus the programmed word. A transfer runs only while two enable bits, held in two different registers, are both set. When a setting that affects the converter or the data format changes during a transfer, the block stops the transfer and starts it again by itself. During this restart the request drops for exactly one cycle and the counter starts over from the programmed value.

Top module: `xdma_ctrl`

## Requirements
- R1: After reset, drq8, drq16 and irq are 0, ctl_word is 0x00, irq_cfg equals the parameter IRQCFG_RST (default 0x05) and drq_cfg equals DRQCFG_RST (default 0x0A).
- R2: A write to index 0xB8 stores only data bits 3:0, and ctl_word bits 7:4 stay 0. Bit 0 is the transfer enable. Bit 1 drives dir_record, bit 2 drives auto_init and bit 3 drives adc_mode.
- R3: A write to index 0xB1 or 0xB2 replaces only bits 7:4 of irq_cfg or drq_cfg respectively. Bits 3:0 keep their previous value.
- R4: A transfer is allowed when ctl_word bit 0 and drq_cfg bit 6 are both 1. When a write changes either bit, an idle block whose transfer is now allowed starts: in the cycle after the write, drq8 rises if index 0xB7 bit 2 is 0, or drq16 rises if it is 1. The two requests are never high together.
- R5: When a write makes the transfer no longer allowed, the request is 0 in the cycle after that write, and it stays 0 while the transfer is not allowed.
- R6: The block length is the word {reg 0xA5, reg 0xA4}, taken when the transfer starts. irq is high for one cycle after exactly 0x10000 minus that word acknowledged transfers.
- R7: In normal mode (auto_init = 0), the overflow also ends the transfer: the request is 0 in the same cycle that irq is 1.
- R8: In auto-initialize mode (auto_init = 1), the overflow reloads the counter and the request stays high. The next irq comes after the same number of transfers.
- R9: dma_ack while no request is high has no effect. It raises no irq and does not advance the count of a later transfer.
- R10: While a transfer runs, three writes force a restart: any write to index 0xA1, a write to 0xB7 that changes bits 3:2, and a write to 0xA8 that changes bits 1:0. After the write the request is 0 for one cycle and then high again, and the count starts over. A write to 0xB7 that changes only bit 5 does not restart.
- R11: A write to 0xB8 that changes bit 1 or bit 3 while a transfer runs stops it. If the transfer is still allowed, it restarts after one idle cycle with the count starting over.
- R12: fmt_signed, fmt_stereo and fmt_wide follow bits 5, 3 and 2 of the last value written to index 0xB7. rate_code holds the last value written to index 0xA1.
- R13: A write to any index other than 0xA1, 0xA4, 0xA5, 0xA8, 0xB1, 0xB2, 0xB7 and 0xB8 changes no output and does not disturb a running transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe from the command decoder |
| wr_idx | input | 8 | Register index of the write |
| wr_data | input | 8 | Register data of the write |
| dma_ack | input | 1 | One acknowledged transfer this cycle |
| drq8 | output | 1 | Request on the byte-wide DMA channel |
| drq16 | output | 1 | Request on the word-wide DMA channel |
| irq | output | 1 | One-cycle pulse on counter overflow |
| fmt_signed | output | 1 | Samples are two's complement |
| fmt_stereo | output | 1 | Samples are stereo |
| fmt_wide | output | 1 | Samples are 16 bits |
| dir_record | output | 1 | Transfer direction is record |
| auto_init | output | 1 | Auto-initialize mode |
| adc_mode | output | 1 | Converter in ADC mode |
| rate_code | output | 8 | Sample-rate code for the rate generator |
| irq_cfg | output | 8 | Interrupt configuration register |
| drq_cfg | output | 8 | Request configuration register |
| ctl_word | output | 8 | Transfer control register |

## Verification
Each register write takes effect at the clock edge that samples it. Configuration outputs and the start or stop of a request can therefore be seen one cycle after the strobe. A forced restart shows a request that is 0 in that first cycle and high again in the second. irq is registered from the acknowledge that causes the overflow, so it is due in the cycle after that acknowledge, together with the fall of the request in normal mode. The bench drives every input on the falling edge and reads the outputs on the next falling edge, half a cycle after the edge that produced them. This is how it counts acknowledges to the cycle across a sweep of block lengths, channel widths and restart causes.

// File: rtl/xdma_pkg.sv
// Shared register indices and field types for the extended DMA controller.
package xdma_pkg;

    localparam logic [7:0] IDX_RATE   = 8'hA1;
    localparam logic [7:0] IDX_LEN_LO = 8'hA4;
    localparam logic [7:0] IDX_LEN_HI = 8'hA5;
    localparam logic [7:0] IDX_ANALOG = 8'hA8;
    localparam logic [7:0] IDX_IRQCFG = 8'hB1;
    localparam logic [7:0] IDX_DRQCFG = 8'hB2;
    localparam logic [7:0] IDX_FMT    = 8'hB7;
    localparam logic [7:0] IDX_CTL    = 8'hB8;

    // Sample format fields kept from the format register.
    typedef struct packed {
        logic is_signed;
        logic stereo;
        logic wide;
    } fmt_t;

    // Transfer control fields; the bit order matches the register layout.
    typedef struct packed {
        logic adc;
        logic auto_init;
        logic record;
        logic xfer_en;
    } ctl_t;

    // Events raised by a register write.
    typedef struct packed {
        logic reeval;     // an enable bit or a direction bit changed
        logic hard_stop;  // a running transfer must stop (and maybe restart)
    } evt_t;

endpackage

// File: rtl/xdma_regfile.sv
// Register store for the extended DMA controller.
// Takes indexed byte writes, applies the per-register write masks, and
// flags the events that the run control acts on. Events are computed from
// the value held before the write and the incoming data.
// Assumes at most one write per cycle; unknown indices are dropped.
module xdma_regfile
    import xdma_pkg::*;
#(
    parameter int         DAT_W      = 8,
    parameter logic [7:0] IRQCFG_RST = 8'h05,
    parameter logic [7:0] DRQCFG_RST = 8'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_idx,
    input  logic [DAT_W-1:0] wr_data,
    output logic [DAT_W-1:0] rate_q,
    output logic [DAT_W-1:0] len_lo_q,
    output logic [DAT_W-1:0] len_hi_q,
    output logic [DAT_W-1:0] irqcfg_q,
    output logic [DAT_W-1:0] drqcfg_q,
    output fmt_t             fmt_q,
    output ctl_t             ctl_q,
    output evt_t             evt,
    output logic             allow_nx
);

    localparam int HALF = DAT_W / 2;

    logic [1:0] analog_q;
    logic hit_rate, hit_lo, hit_hi, hit_analog, hit_irq, hit_drq, hit_fmt, hit_ctl;
    ctl_t       ctl_wr;
    fmt_t       fmt_wr;
    logic [DAT_W-1:0] drq_wr;

    // Decode which register, if any, the current write targets.
    always_comb begin
        hit_rate   = wr_en && (wr_idx == IDX_RATE);
        hit_lo     = wr_en && (wr_idx == IDX_LEN_LO);
        hit_hi     = wr_en && (wr_idx == IDX_LEN_HI);
        hit_analog = wr_en && (wr_idx == IDX_ANALOG);
        hit_irq    = wr_en && (wr_idx == IDX_IRQCFG);
        hit_drq    = wr_en && (wr_idx == IDX_DRQCFG);
        hit_fmt    = wr_en && (wr_idx == IDX_FMT);
        hit_ctl    = wr_en && (wr_idx == IDX_CTL);
    end

    // Shape the incoming data into each register's stored form.
    always_comb begin
        ctl_wr = ctl_t'(wr_data[3:0]);
        fmt_wr = '{is_signed: wr_data[5], stereo: wr_data[3], wide: wr_data[2]};
        drq_wr = {wr_data[DAT_W-1:HALF], drqcfg_q[HALF-1:0]};
    end

    // Derive restart / re-evaluation events and the post-write permission.
    always_comb begin
        logic ctl_dir_chg, ctl_en_chg, drq_en_chg, fmt_chg, ana_chg;
        ctl_dir_chg = hit_ctl && ((ctl_wr.record != ctl_q.record) || (ctl_wr.adc != ctl_q.adc));
        ctl_en_chg  = hit_ctl && (ctl_wr.xfer_en != ctl_q.xfer_en);
        drq_en_chg  = hit_drq && (wr_data[6] != drqcfg_q[6]);
        fmt_chg     = hit_fmt && ((fmt_wr.stereo != fmt_q.stereo) || (fmt_wr.wide != fmt_q.wide));
        ana_chg     = hit_analog && (wr_data[1:0] != analog_q);
        evt.reeval    = ctl_dir_chg || ctl_en_chg || drq_en_chg;
        evt.hard_stop = ctl_dir_chg || fmt_chg || ana_chg || hit_rate;
        allow_nx = (hit_ctl ? ctl_wr.xfer_en : ctl_q.xfer_en)
                && (hit_drq ? wr_data[6] : drqcfg_q[6]);
    end

    // Store register contents with their write masks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q   <= '0;
            len_lo_q <= '0;
            len_hi_q <= '0;
            analog_q <= '0;
            irqcfg_q <= IRQCFG_RST;
            drqcfg_q <= DRQCFG_RST;
            fmt_q    <= '0;
            ctl_q    <= '0;
        end else begin
            if (hit_rate)   rate_q   <= wr_data;
            if (hit_lo)     len_lo_q <= wr_data;
            if (hit_hi)     len_hi_q <= wr_data;
            if (hit_analog) analog_q <= wr_data[1:0];
            if (hit_irq)    irqcfg_q <= {wr_data[DAT_W-1:HALF], irqcfg_q[HALF-1:0]};
            if (hit_drq)    drqcfg_q <= drq_wr;
            if (hit_fmt)    fmt_q    <= fmt_wr;
            if (hit_ctl)    ctl_q    <= ctl_wr;
        end
    end

endmodule

// File: rtl/xdma_runctl.sv
// Run control for the extended DMA controller.
// Keeps the active flag and a one-cycle restart-pending flag. A start
// loads the transfer counter. A forced stop while running leaves exactly
// one idle cycle before the pending restart, taken only if still allowed.
// Assumes the counter overflow and the events arrive in the same cycle
// as the write or acknowledge that caused them.
module xdma_runctl
    import xdma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  evt_t evt,
    input  logic allow_nx,
    input  logic ovf,
    input  logic auto_init,
    output logic act_q,
    output logic load
);

    logic pend_q;
    logic act_d, pend_d;

    // Choose the next run state from events, overflow and pending restart.
    always_comb begin
        act_d  = act_q;
        pend_d = 1'b0;
        load   = 1'b0;
        if (ovf && !auto_init) begin
            act_d = 1'b0;
        end
        if (evt.hard_stop && act_q) begin
            act_d  = 1'b0;
            pend_d = allow_nx;
        end else if (evt.reeval && allow_nx && !act_q) begin
            act_d = 1'b1;
            load  = 1'b1;
        end else if (evt.reeval && !allow_nx && act_q) begin
            act_d = 1'b0;
        end
        if (pend_q && allow_nx) begin
            act_d = 1'b1;
            load  = 1'b1;
        end
    end

    // Register the run state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            act_q  <= act_d;
            pend_q <= pend_d;
        end
    end

endmodule

// File: rtl/xdma_xfer_cnt.sv
// Transfer counter for the extended DMA controller.
// Counts acknowledged transfers upward from a two's-complement start
// value. When it passes the all-ones value it flags overflow and
// registers a one-cycle interrupt pulse. In auto-initialize mode it then
// reloads; otherwise it wraps to zero and the run control ends the transfer.
// Assumes load and advance never coincide.
module xdma_xfer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             adv,
    input  logic             auto_init,
    input  logic [CNT_W-1:0] reload,
    output logic             ovf,
    output logic             irq_q
);

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    logic [CNT_W-1:0] cnt_q;

    // Flag the acknowledge that carries the counter through zero.
    always_comb begin
        ovf = adv && (cnt_q == CNT_TOP);
    end

    // Load, advance or reload the counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= reload;
        end else if (ovf) begin
            cnt_q <= auto_init ? reload : '0;
        end else if (adv) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= ovf;
    end

endmodule

// File: rtl/xdma_ctrl.sv
// Extended-mode DMA transfer controller (top).
// Joins the register store, the run control and the transfer counter.
// It also steers the request onto the byte-wide or word-wide channel
// according to the sample width. Acknowledges count only while a
// transfer is active.
module xdma_ctrl
    import xdma_pkg::*;
#(
    parameter int         DAT_W      = 8,
    parameter logic [7:0] IRQCFG_RST = 8'h05,
    parameter logic [7:0] DRQCFG_RST = 8'h0A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       wr_idx,
    input  logic [DAT_W-1:0] wr_data,
    input  logic             dma_ack,
    output logic             drq8,
    output logic             drq16,
    output logic             irq,
    output logic             fmt_signed,
    output logic             fmt_stereo,
    output logic             fmt_wide,
    output logic             dir_record,
    output logic             auto_init,
    output logic             adc_mode,
    output logic [DAT_W-1:0] rate_code,
    output logic [DAT_W-1:0] irq_cfg,
    output logic [DAT_W-1:0] drq_cfg,
    output logic [DAT_W-1:0] ctl_word
);

    localparam int CNT_W = 2 * DAT_W;

    logic [DAT_W-1:0] len_lo, len_hi;
    fmt_t fmt;
    ctl_t ctl;
    evt_t evt;
    logic allow_nx, act, load, ovf, adv;

    xdma_regfile #(
        .DAT_W(DAT_W), .IRQCFG_RST(IRQCFG_RST), .DRQCFG_RST(DRQCFG_RST)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rate_q(rate_code), .len_lo_q(len_lo), .len_hi_q(len_hi),
        .irqcfg_q(irq_cfg), .drqcfg_q(drq_cfg), .fmt_q(fmt), .ctl_q(ctl),
        .evt(evt), .allow_nx(allow_nx)
    );

    xdma_runctl u_run (
        .clk(clk), .rst_n(rst_n), .evt(evt), .allow_nx(allow_nx), .ovf(ovf),
        .auto_init(ctl.auto_init), .act_q(act), .load(load)
    );

    xdma_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .adv(adv), .auto_init(ctl.auto_init),
        .reload({len_hi, len_lo}), .ovf(ovf), .irq_q(irq)
    );

    // Gate acknowledges and steer the request by sample width.
    always_comb begin
        adv   = dma_ack && act;
        drq8  = act && !fmt.wide;
        drq16 = act && fmt.wide;
    end

    // Expose configuration fields.
    always_comb begin
        fmt_signed = fmt.is_signed;
        fmt_stereo = fmt.stereo;
        fmt_wide   = fmt.wide;
        dir_record = ctl.record;
        auto_init  = ctl.auto_init;
        adc_mode   = ctl.adc;
        ctl_word   = {{(DAT_W-4){1'b0}}, ctl};
    end

endmodule

// File: rtl/xdma_ctrl_chk.sv
// Assertion checker for xdma_ctrl, attached by bind below.
module xdma_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_idx,
    input logic [7:0] wr_data,
    input logic       dma_ack,
    input logic       drq8,
    input logic       drq16,
    input logic       irq,
    input logic       auto_init,
    input logic [7:0] drq_cfg,
    input logic [7:0] ctl_word
);

    a_r4_one_channel: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({drq8, drq16}));

    a_r5_needs_both_enables: assert property (@(posedge clk) disable iff (!rst_n)
        !(drq_cfg[6] && ctl_word[0]) |-> !(drq8 || drq16));

    a_r3_low_nibble_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'hB2) |=> (drq_cfg[3:0] == $past(drq_cfg[3:0])));

    a_r6_irq_from_ack: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($past(dma_ack) && $past(drq8 || drq16)));

    a_r7_normal_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !$past(auto_init)) |-> !(drq8 || drq16));

    a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_ack && !(drq8 || drq16)) |=> !irq);

    a_r10_rate_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'hA1 && (drq8 || drq16)) |=> !(drq8 || drq16));

    a_r11_dir_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == 8'hB8 && (drq8 || drq16) && (wr_data[1] != ctl_word[1]))
        |=> !(drq8 || drq16));

endmodule

bind xdma_ctrl xdma_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .dma_ack(dma_ack), .drq8(drq8), .drq16(drq16), .irq(irq), .auto_init(auto_init),
    .drq_cfg(drq_cfg), .ctl_word(ctl_word)
);

// File: tb/tb_xdma_ctrl.sv
// Self-checking bench for xdma_ctrl: inputs change on the falling edge,
// outputs are read on the following falling edge.
module tb_xdma_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_idx = '0;
    logic [7:0] wr_data = '0;
    logic       dma_ack = 1'b0;
    logic       drq8, drq16, irq;
    logic       fmt_signed, fmt_stereo, fmt_wide, dir_record, auto_init, adc_mode;
    logic [7:0] rate_code, irq_cfg, drq_cfg, ctl_word;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    xdma_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .dma_ack(dma_ack), .drq8(drq8), .drq16(drq16), .irq(irq),
        .fmt_signed(fmt_signed), .fmt_stereo(fmt_stereo), .fmt_wide(fmt_wide),
        .dir_record(dir_record), .auto_init(auto_init), .adc_mode(adc_mode),
        .rate_code(rate_code), .irq_cfg(irq_cfg), .drq_cfg(drq_cfg), .ctl_word(ctl_word)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] idx, input logic [7:0] dat);
        wr_en = 1'b1; wr_idx = idx; wr_data = dat;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic ack();
        dma_ack = 1'b1;
        @(negedge clk);
        dma_ack = 1'b0;
    endtask

    task automatic set_len(input int n);
        logic [15:0] r;
        r = 16'(32'h10000 - n);
        wr(8'hA4, r[7:0]);
        wr(8'hA5, r[15:8]);
    endtask

    // Acknowledge n transfers; irq only after the last one.
    task automatic burst(input string req, input int n);
        for (int k = 1; k <= n; k++) begin
            ack();
            chk(req, irq, (k == n));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_err++;
            n_chk++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 drq", {drq16, drq8}, 0);
        chk("R1 irq", irq, 0);
        chk("R1 ctl", ctl_word, 8'h00);
        chk("R1 irqcfg", irq_cfg, 8'h05);
        chk("R1 drqcfg", drq_cfg, 8'h0A);

        // R2 / R3 write masks
        wr(8'hB8, 8'hF2);
        chk("R2 ctl mask", ctl_word, 8'h02);
        chk("R2 dir_record", dir_record, 1);
        wr(8'hB8, 8'h0C);
        chk("R2 auto/adc", {adc_mode, auto_init, dir_record}, 3'b110);
        wr(8'hB8, 8'h00);
        wr(8'hB1, 8'h3C);
        chk("R3 irqcfg", irq_cfg, 8'h35);
        wr(8'hB2, 8'hFF);
        chk("R3 drqcfg", drq_cfg, 8'hFA);
        wr(8'hB2, 8'h40);
        chk("R3 drqcfg low kept", drq_cfg, 8'h4A);

        // R12 format and rate fields
        wr(8'hB7, 8'h2C);
        chk("R12 fmt", {fmt_signed, fmt_stereo, fmt_wide}, 3'b111);
        wr(8'hB7, 8'h20);
        chk("R12 fmt", {fmt_signed, fmt_stereo, fmt_wide}, 3'b100);
        wr(8'hA1, 8'h9C);
        chk("R12 rate", rate_code, 8'h9C);

        // R4 / R6 / R7 sweep over block length and channel width
        for (int w = 0; w < 2; w++) begin
            for (int n = 1; n <= 16; n++) begin
                set_len(n);
                wr(8'hB7, (w == 1) ? 8'h04 : 8'h00);
                wr(8'hB8, 8'h01);
                chk("R4 start channel", {drq16, drq8}, (w == 1) ? 2 : 1);
                burst("R6 count", n);
                chk("R7 normal end", {drq16, drq8}, 0);
                @(negedge clk);
                chk("R6 pulse width", irq, 0);
                wr(8'hB8, 8'h00);
            end
        end

        // R8 auto-initialize on the wide channel
        set_len(3);
        wr(8'hB7, 8'h04);
        wr(8'hB8, 8'h05);
        chk("R8 start", {drq16, drq8}, 2);
        for (int r = 0; r < 2; r++) begin
            burst("R8 reload count", 3);
            chk("R8 keeps running", drq16, 1);
        end
        @(negedge clk);
        chk("R8 pulse width", irq, 0);
        wr(8'hB8, 8'h00);
        chk("R5 stop by ctl", {drq16, drq8}, 0);
        wr(8'hB7, 8'h00);

        // R9 acknowledge while idle
        for (int k = 0; k < 5; k++) begin
            ack();
            chk("R9 idle ack", irq, 0);
        end
        set_len(4);
        wr(8'hB8, 8'h01);
        burst("R9 count after idle acks", 4);

        // R5 the second enable bit
        wr(8'hB8, 8'h00);
        wr(8'hB8, 8'h01);
        ack();
        wr(8'hB2, 8'h00);
        chk("R5 stop by drqcfg", {drq16, drq8}, 0);
        chk("R5 drqcfg", drq_cfg, 8'h0A);
        @(negedge clk);
        @(negedge clk);
        chk("R5 stays idle", {drq16, drq8}, 0);
        wr(8'hB2, 8'h40);
        chk("R4 start by drqcfg", drq8, 1);
        burst("R6 count restarts", 4);

        // R10 forced restarts
        for (int c = 0; c < 3; c++) begin
            wr(8'hB8, 8'h00);
            wr(8'hB8, 8'h01);
            ack();
            ack();
            case (c)
                0: wr(8'hA1, 8'h55);
                1: wr(8'hB7, 8'h08);
                default: wr(8'hA8, 8'h01);
            endcase
            chk("R10 restart gap", {drq16, drq8}, 0);
            @(negedge clk);
            chk("R10 restart resume", {drq16, drq8}, 1);
            burst("R10 count restarts", 4);
        end
        chk("R12 rate after restart", rate_code, 8'h55);
        chk("R12 stereo", fmt_stereo, 1);

        // R10 non-restarting changes
        wr(8'hB8, 8'h00);
        wr(8'hB8, 8'h01);
        ack();
        ack();
        wr(8'hB7, 8'h28);
        chk("R10 signed only no restart", drq8, 1);
        wr(8'hA8, 8'h11);
        chk("R10 analog high bits no restart", drq8, 1);
        burst("R10 count continues", 2);

        // R13 unknown indices
        wr(8'hB8, 8'h00);
        wr(8'hB8, 8'h01);
        ack();
        wr(8'hB3, 8'h00);
        wr(8'hA0, 8'hFF);
        wr(8'hC0, 8'h00);
        chk("R13 still running", drq8, 1);
        chk("R13 ctl", ctl_word, 8'h01);
        chk("R13 rate", rate_code, 8'h55);
        chk("R13 cfg", {irq_cfg, drq_cfg}, 16'h354A);
        burst("R13 count continues", 3);

        // R11 direction change while running
        wr(8'hB8, 8'h00);
        wr(8'hB8, 8'h01);
        ack();
        wr(8'hB8, 8'h03);
        chk("R11 stop", {drq16, drq8}, 0);
        @(negedge clk);
        chk("R11 restart", drq8, 1);
        chk("R11 record", dir_record, 1);
        burst("R11 count restarts", 4);
        wr(8'hB8, 8'h00);
        wr(8'hB8, 8'h01);
        wr(8'hB2, 8'h00);
        wr(8'hB8, 8'h09);
        @(negedge clk);
        chk("R11 no restart when disallowed", {drq16, drq8}, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule